// File: doc/BRIEF.md
# RTC Register Guard and Init-Mode Controller

This block sits between a simple register bus and the calendar core of a real-time clock. It holds the time, date, prescaler and hour-format values. Software can change them only after it has written a two-byte key to a dedicated key register. Time, date and prescaler can then be loaded only inside an initialisation window. Software opens that window with a request bit. The block grants it on the next slow RTC tick and signals the grant with an active flag.

When the window closes, or when software clears it by hand, a synchronisation flag drops. The flag comes back after a fixed number of RTC ticks, which tells software that the calendar shadow copies are coherent again. A sticky flag records that a calendar with a non-zero year has been loaded since reset.

Three small state machines do the work.
- **Key sequencer** (`KEY_LOCKED`, `KEY_HALF`, `KEY_OPEN`):
  - `KEY_LOCKED` to `KEY_HALF` on the first key.
  - `KEY_HALF` to `KEY_OPEN` on the second key.
  - `KEY_HALF` stays in `KEY_HALF` on a repeated first key.
  - Every other key write goes to `KEY_LOCKED`.
- **Init sequencer** (`INI_IDLE`, `INI_WAIT_TICK`, `INI_ACTIVE`):
  - `INI_IDLE` to `INI_WAIT_TICK` when the request is set.
  - `INI_WAIT_TICK` to `INI_ACTIVE` on a tick.
  - Either waiting state returns to `INI_IDLE` when the request is dropped.
- **Resync tracker** (`SYN_VALID`, `SYN_HOLD`, `SYN_COUNT`):
  - Any state goes to `SYN_HOLD` while init is active.
  - `SYN_HOLD` or `SYN_VALID` goes to `SYN_COUNT` on release or on a software clear.
  - `SYN_COUNT` goes to `SYN_VALID` after the tick count is reached, and restarts on a new clear.

Top module: `rtc_regguard`

## Requirements
- R1: The key register (offset 0x24, low 8 bits compared, upper bits ignored) opens the guard only when 0xCA is written and the next key-register write is 0x53.
- R2: Several key-register writes close the guard: any value other than 0x53 while half-unlocked, except 0xCA, which keeps it waiting for 0x53; 0x53 while locked; and any value at all while open. After a wrong key, 0x53 has no effect until 0xCA is written again.
- R3: The control register (offset 0x18) stores only bit 6, the hour format, where 0 means 24-hour mode; its other bits read as 0. A write to it takes effect only while the guard is open.
- R4: Status register (offset 0x0C) bit 7 is the init request. It reads back as written, but writes change it only while the guard is open.
- R5: Status bit 6 (init active) rises in the cycle after the first RTC tick that finds the request pending. It never rises if the request is withdrawn before such a tick, and it falls one clock after the request is cleared.
- R6: Writes to time (0x00, mask 0x003F7F7F), date (0x04, mask 0x00FFFF3F) and prescaler (0x10, mask 0x007F7FFF) are stored only while the guard is open and init is active; otherwise they are ignored.
- R7: Status bit 5 (synchronised) is low while init is active. It is cleared by a status write with bit 5 at 0, whether the guard is open or locked. It rises after 2 RTC ticks counted from the release or from the last clear.
- R8: Status bit 4 (calendar initialised) sets when an accepted date write carries a non-zero year field (bits 23:16), and stays set until reset.
- R9: After reset:
  - time and date read 0;
  - the prescaler reads 0x007F00FF;
  - the control register reads 0;
  - the status register reads 0.
- R10: The key register and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| rtc_tick | input | 1 | One-cycle pulse marking each slow RTC clock period |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The key sequencer is driven from a table of key bytes. The table covers the correct pair, the second key alone, a wrong byte between the two keys, a repeated first key, and relocking with 0xFF and with 0x00. After every key write the bench tries to flip the hour-format bit, so the guard state is read out through the control register. Directed sequences then load time, date and prescaler values inside and outside the init window, with the guard open and closed, and with year fields of zero and non-zero. Further sequences cancel a pending request before its tick, and restart a resync count part-way through, to separate the timing of the active and synchronised flags from plain register writes.

// File: rtl/rtc_guard_pkg.sv
package rtc_guard_pkg;

    localparam int OFF_TIME  = 8'h00;
    localparam int OFF_DATE  = 8'h04;
    localparam int OFF_STAT  = 8'h0C;
    localparam int OFF_PRESC = 8'h10;
    localparam int OFF_CTRL  = 8'h18;
    localparam int OFF_KEY   = 8'h24;

    localparam int ST_REQ  = 7;
    localparam int ST_ACT  = 6;
    localparam int ST_SYNC = 5;
    localparam int ST_INIT = 4;
    localparam int CTL_FMT = 6;
    localparam int YEAR_LO = 16;
    localparam int YEAR_HI = 23;

    typedef enum logic [1:0] {KEY_LOCKED, KEY_HALF, KEY_OPEN} key_state_t;
    typedef enum logic [1:0] {INI_IDLE, INI_WAIT_TICK, INI_ACTIVE} init_state_t;
    typedef enum logic [1:0] {SYN_VALID, SYN_HOLD, SYN_COUNT} sync_state_t;

endpackage

// File: rtl/rtc_key_gate.sv
module rtc_key_gate
    import rtc_guard_pkg::*;
#(
    parameter int          KEY_W      = 8,
    parameter logic [7:0]  FIRST_KEY  = 8'hCA,
    parameter logic [7:0]  SECOND_KEY = 8'h53
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_we,
    input  logic [KEY_W-1:0] key_val,
    output logic             unlocked
);

    key_state_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= KEY_LOCKED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            KEY_LOCKED: if (key_we && key_val == KEY_W'(FIRST_KEY)) st_d = KEY_HALF;
            KEY_HALF: if (key_we) begin
                if (key_val == KEY_W'(SECOND_KEY))     st_d = KEY_OPEN;
                else if (key_val == KEY_W'(FIRST_KEY)) st_d = KEY_HALF;
                else                                   st_d = KEY_LOCKED;
            end
            KEY_OPEN: if (key_we) st_d = KEY_LOCKED;
            default:  st_d = KEY_LOCKED;
        endcase
    end

    always_comb unlocked = (st_q == KEY_OPEN);

    // R1: opening is always preceded by the second key
    assert_open_after_second_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(key_we && key_val == KEY_W'(SECOND_KEY)));

    // R2: a byte that is neither key always leaves the guard closed
    assert_bad_key_locks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_we && key_val != KEY_W'(FIRST_KEY) && key_val != KEY_W'(SECOND_KEY)) |=> !unlocked);

endmodule

// File: rtl/rtc_init_seq.sv
module rtc_init_seq
    import rtc_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic tick,
    output logic active
);

    init_state_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= INI_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            INI_IDLE:      if (req) st_d = INI_WAIT_TICK;
            INI_WAIT_TICK: begin
                if (!req)      st_d = INI_IDLE;
                else if (tick) st_d = INI_ACTIVE;
            end
            INI_ACTIVE:    if (!req) st_d = INI_IDLE;
            default:       st_d = INI_IDLE;
        endcase
    end

    always_comb active = (st_q == INI_ACTIVE);

    // R5: the grant is only given on a tick
    assert_grant_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(tick && req));

    // R5: releasing the request ends init mode in one clock
    assert_release_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !req) |=> !active);

endmodule

// File: rtl/rtc_sync_track.sv
module rtc_sync_track
    import rtc_guard_pkg::*;
#(
    parameter int SYNC_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic clear,
    input  logic tick,
    output logic synced
);

    localparam int CNT_W = $clog2(SYNC_TICKS + 1);

    sync_state_t       st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SYN_COUNT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            SYN_VALID: begin
                if (hold)       st_d = SYN_HOLD;
                else if (clear) begin st_d = SYN_COUNT; cnt_d = '0; end
            end
            SYN_HOLD: begin
                if (!hold) begin st_d = SYN_COUNT; cnt_d = '0; end
            end
            SYN_COUNT: begin
                if (hold)       st_d = SYN_HOLD;
                else if (clear) cnt_d = '0;
                else if (tick) begin
                    if (cnt_q == CNT_W'(SYNC_TICKS - 1)) st_d = SYN_VALID;
                    else                                 cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: st_d = SYN_COUNT;
        endcase
    end

    always_comb synced = (st_q == SYN_VALID);

    // R7: never synchronised while the calendar is held in init mode
    assert_low_in_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !synced);

    // R7: the flag only rises on a tick
    assert_rise_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(synced) |-> $past(tick));

endmodule

// File: rtl/rtc_regguard.sv
module rtc_regguard
    import rtc_guard_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 32,
    parameter int          KEY_W       = 8,
    parameter logic [7:0]  FIRST_KEY   = 8'hCA,
    parameter logic [7:0]  SECOND_KEY  = 8'h53,
    parameter int          SYNC_TICKS  = 2,
    parameter logic [31:0] PRESC_RESET = 32'h007F_00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              rtc_tick,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [DATA_W-1:0] TIME_MASK  = DATA_W'(32'h003F_7F7F);
    localparam logic [DATA_W-1:0] DATE_MASK  = DATA_W'(32'h00FF_FF3F);
    localparam logic [DATA_W-1:0] PRESC_MASK = DATA_W'(32'h007F_7FFF);

    logic              unlocked, init_active, synced;
    logic              hit_time, hit_date, hit_stat, hit_presc, hit_ctrl, hit_key;
    logic              cal_load, sync_clear;
    logic [DATA_W-1:0] time_q, date_q, presc_q;
    logic              fmt_q, req_q, inits_q;

    always_comb begin
        hit_time  = bus_we && bus_addr == ADDR_W'(OFF_TIME);
        hit_date  = bus_we && bus_addr == ADDR_W'(OFF_DATE);
        hit_stat  = bus_we && bus_addr == ADDR_W'(OFF_STAT);
        hit_presc = bus_we && bus_addr == ADDR_W'(OFF_PRESC);
        hit_ctrl  = bus_we && bus_addr == ADDR_W'(OFF_CTRL);
        hit_key   = bus_we && bus_addr == ADDR_W'(OFF_KEY);
        cal_load   = unlocked && init_active;
        sync_clear = hit_stat && !bus_wdata[ST_SYNC];
    end

    rtc_key_gate #(
        .KEY_W      (KEY_W),
        .FIRST_KEY  (FIRST_KEY),
        .SECOND_KEY (SECOND_KEY)
    ) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_we   (hit_key),
        .key_val  (bus_wdata[KEY_W-1:0]),
        .unlocked (unlocked)
    );

    rtc_init_seq u_init (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req_q),
        .tick   (rtc_tick),
        .active (init_active)
    );

    rtc_sync_track #(.SYNC_TICKS(SYNC_TICKS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (init_active),
        .clear  (sync_clear),
        .tick   (rtc_tick),
        .synced (synced)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q  <= '0;
            date_q  <= '0;
            presc_q <= DATA_W'(PRESC_RESET);
            fmt_q   <= 1'b0;
            req_q   <= 1'b0;
            inits_q <= 1'b0;
        end else begin
            if (hit_time && cal_load)  time_q  <= bus_wdata & TIME_MASK;
            if (hit_date && cal_load)  date_q  <= bus_wdata & DATE_MASK;
            if (hit_presc && cal_load) presc_q <= bus_wdata & PRESC_MASK;
            if (hit_ctrl && unlocked)  fmt_q   <= bus_wdata[CTL_FMT];
            if (hit_stat && unlocked)  req_q   <= bus_wdata[ST_REQ];
            if (hit_date && cal_load && bus_wdata[YEAR_HI:YEAR_LO] != '0) inits_q <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(OFF_TIME):  bus_rdata = time_q;
            ADDR_W'(OFF_DATE):  bus_rdata = date_q;
            ADDR_W'(OFF_PRESC): bus_rdata = presc_q;
            ADDR_W'(OFF_CTRL):  bus_rdata[CTL_FMT] = fmt_q;
            ADDR_W'(OFF_STAT): begin
                bus_rdata[ST_REQ]  = req_q;
                bus_rdata[ST_ACT]  = init_active;
                bus_rdata[ST_SYNC] = synced;
                bus_rdata[ST_INIT] = inits_q;
            end
            default: bus_rdata = '0;
        endcase
    end

    // R6: calendar values hold still outside an open init window
    assert_time_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(unlocked && init_active) |=> $stable(time_q) && $stable(date_q) && $stable(presc_q));

    // R3: the hour format holds still while locked
    assert_fmt_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(fmt_q));

    // R8: the initialised flag is sticky
    assert_inits_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inits_q |=> inits_q);

endmodule

// File: tb/rtc_regguard_tb.sv
module rtc_regguard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        rtc_tick = 1'b0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_regguard u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .rtc_tick  (rtc_tick),
        .bus_rdata (bus_rdata)
    );

    localparam logic [7:0] A_TIME = 8'h00, A_DATE = 8'h04, A_STAT = 8'h0C,
                           A_PRESC = 8'h10, A_CTRL = 8'h18, A_KEY = 8'h24;

    // key byte, expected guard-open state afterwards
    localparam int NVEC = 13;
    localparam logic [8:0] KEY_VEC [NVEC] = '{
        {8'h53, 1'b0}, {8'hCA, 1'b0}, {8'h53, 1'b1}, {8'h00, 1'b0},
        {8'hCA, 1'b0}, {8'h11, 1'b0}, {8'h53, 1'b0}, {8'hCA, 1'b0},
        {8'hCA, 1'b0}, {8'h53, 1'b1}, {8'hFF, 1'b0}, {8'hCA, 1'b0},
        {8'h53, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic tk();
        @(negedge clk);
        rtc_tick = 1'b1;
        @(negedge clk);
        rtc_tick = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic unlock();
        wr(A_KEY, 32'hCA);
        wr(A_KEY, 32'h53);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] ctl_model;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset values
        rd(A_STAT, v);  check("R9 status", v, 32'h0);
        rd(A_TIME, v);  check("R9 time", v, 32'h0);
        rd(A_DATE, v);  check("R9 date", v, 32'h0);
        rd(A_PRESC, v); check("R9 prescaler", v, 32'h007F00FF);
        rd(A_CTRL, v);  check("R9 control", v, 32'h0);
        // R10: key register and unmapped offsets
        rd(A_KEY, v);   check("R10 key reads zero", v, 32'h0);
        rd(8'h08, v);   check("R10 unmapped reads zero", v, 32'h0);

        // R1 R2 R3: key table, guard state probed through the control register
        ctl_model = 32'h0;
        for (int i = 0; i < NVEC; i++) begin
            wr(A_KEY, {24'h0, KEY_VEC[i][8:1]});
            wr(A_CTRL, ctl_model ^ 32'hFFFF_FFFF);
            if (KEY_VEC[i][0]) ctl_model = ctl_model ^ 32'h40;
            rd(A_CTRL, v);
            check($sformatf("R1 R2 R3 key vector %0d", i), v, ctl_model);
        end

        // R6: guard open but no init window
        wr(A_TIME, 32'h0011_1111);
        rd(A_TIME, v); check("R6 time ignored outside init", v, 32'h0);

        // R4 R5: request, then grant on tick
        wr(A_STAT, 32'h80);
        rd(A_STAT, v); check("R4 request reads back", v & 32'hC0, 32'h80);
        idle();
        rd(A_STAT, v); check("R5 not active before tick", v & 32'h40, 32'h0);
        tk();
        rd(A_STAT, v); check("R5 R7 active after tick, sync low", v, 32'hC0);

        // R6 R8: loads inside init window
        wr(A_TIME, 32'hFFFF_FFFF);
        rd(A_TIME, v); check("R6 time mask", v, 32'h003F7F7F);
        wr(A_DATE, 32'h0000_1231);
        rd(A_DATE, v); check("R6 date year zero", v, 32'h00001231);
        rd(A_STAT, v); check("R8 no flag for year zero", v & 32'h10, 32'h0);
        wr(A_DATE, 32'hFF25_4615);
        rd(A_DATE, v); check("R6 date mask", v, 32'h00254615);
        rd(A_STAT, v); check("R8 flag after nonzero year", v & 32'h10, 32'h10);
        wr(A_PRESC, 32'h1234_5678);
        rd(A_PRESC, v); check("R6 prescaler mask", v, 32'h00345678);

        // R6 R4: locked while in init
        wr(A_KEY, 32'hFF);
        wr(A_TIME, 32'h1);
        rd(A_TIME, v); check("R6 time ignored while locked", v, 32'h003F7F7F);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); check("R4 request kept while locked", v & 32'hC0, 32'hC0);

        // R5 R7: leave init, resync
        unlock();
        wr(A_STAT, 32'h20);
        rd(A_STAT, v); check("R5 still active one cycle", v & 32'h40, 32'h40);
        idle();
        rd(A_STAT, v); check("R5 inactive after release", v & 32'h40, 32'h0);
        idle();
        tk();
        rd(A_STAT, v); check("R7 low after one tick", v & 32'h20, 32'h0);
        tk();
        rd(A_STAT, v); check("R7 set after two ticks", v, 32'h30);

        // R7: software clear while locked, with restart
        wr(A_KEY, 32'h00);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); check("R7 cleared by write", v, 32'h10);
        tk();
        wr(A_STAT, 32'h0);
        tk();
        rd(A_STAT, v); check("R7 restart on second clear", v & 32'h20, 32'h0);
        tk();
        rd(A_STAT, v); check("R7 set after restart", v, 32'h30);

        // R5: request withdrawn before tick
        unlock();
        wr(A_STAT, 32'hA0);
        wr(A_STAT, 32'h20);
        idle();
        tk();
        rd(A_STAT, v); check("R5 cancelled request never active", v & 32'hC0, 32'h0);
        rd(A_CTRL, v); check("R3 control retained", v, ctl_model);

        // R9 R8: reset mid-run clears sticky flag and calendar
        @(negedge clk); rst_n = 1'b0;
        idle();
        rst_n = 1'b1;
        rd(A_STAT, v); check("R8 R9 status after reset", v, 32'h0);
        rd(A_TIME, v); check("R9 time after reset", v, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule